// File: doc/BRIEF.md
# Alignment Marker Slot Overwriter

This block sits in a two-flow PCS data path that carries 257-bit transcoded blocks. The upstream sublayer has already left room for alignment markers in the stream. Each flow carries one block per beat, and the flows travel side by side in a valid/ready stream. A slot-start flag marks the first beat of each reserved marker slot. On transmit the block never inserts a beat and never stalls on its own. For all eight beats of a slot it replaces every flow's block with a word from a programmable marker bank. The bank holds marker content in the usual 800G Ethernet marker encoding.

On receive the same slot framing applies. While the alignment lock input is high, the eight blocks of the slot in every flow are replaced by one fixed, known pattern, so the descrambler that follows sees constant content. While lock is low, received marker regions pass through unchanged. Each direction keeps its own slot counter and its own sticky error flag. The flag records a slot-start flag that arrives while a slot is still in progress.

Top module: `am_slot_overwrite`

## Requirements
- R1: After reset both output valids are 0, both input readies are 1 and both slot error flags are 0.
- R2: A beat that is not part of a marker slot reaches the output of its direction one clock after it is accepted, with data and slot-start flag unchanged.
- R3: While an output is valid and its ready is low, that output's data, flag and valid hold steady. The matching input ready is low in that case and high otherwise, so no beat is dropped or duplicated.
- R4: On transmit, a slot-start beat and the next seven accepted beats form slot blocks k = 0..7. In flow f (flow f occupies data bits [f*257 +: 257]), each of these blocks is replaced by bank word [(f*8+k)*257 +: 257].
- R5: The transmit side emits exactly one output beat for each accepted input beat and inserts none of its own. The slot-start flag passes to the output with its beat.
- R6: On receive with lock high, slot block k in every flow is replaced by a 257-bit pattern whose bit j equals bit (j mod 8) of the byte 0xC3 XOR k. The pattern is the same in all flows.
- R7: On receive with lock low, slot beats pass through unmodified. Lock is sampled on each accepted beat.
- R8: A slot-start flag that arrives while a slot is mid-way (blocks 1..7) sets that direction's slot error flag. The flag is otherwise ignored: the current slot still ends after eight blocks in total.
- R9: The slot position advances only on accepted beats, so a stall inside a slot does not skip or repeat a block index.
- R10: A slot error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| am_bank | input | 4112 | Transmit marker words, flow-major, 8 per flow |
| tx_in_valid | input | 1 | Transmit input beat valid |
| tx_in_ready | output | 1 | Transmit input beat accepted |
| tx_in_data | input | 514 | Transmit blocks, one per flow |
| tx_in_sos | input | 1 | Transmit slot-start flag |
| tx_out_valid | output | 1 | Transmit output valid |
| tx_out_ready | input | 1 | Transmit output ready |
| tx_out_data | output | 514 | Transmit output blocks |
| tx_out_sos | output | 1 | Transmit slot-start flag, passed along |
| tx_slot_err | output | 1 | Sticky transmit mid-slot start error |
| rx_lock | input | 1 | Alignment lock |
| rx_in_valid | input | 1 | Receive input beat valid |
| rx_in_ready | output | 1 | Receive input beat accepted |
| rx_in_data | input | 514 | Receive blocks, one per flow |
| rx_in_sos | input | 1 | Receive slot-start flag |
| rx_out_valid | output | 1 | Receive output valid |
| rx_out_ready | input | 1 | Receive output ready |
| rx_out_data | output | 514 | Receive output blocks |
| rx_out_sos | output | 1 | Receive slot-start flag, passed along |
| rx_slot_err | output | 1 | Sticky receive mid-slot start error |

## Verification
A wrong slot counter shows on the next output beat. Either a bank word appears where pass-through data was expected, or the wrong bank word or fill byte appears. The bench checks every beat of each slot against its index, so an off-by-one shows within the same slot, and so does a count that moves during a stall. A lost or repeated beat in the output register breaks the one-cycle correspondence on the very next cycle. A bad error state shows as a flag that rises without a mid-slot start, or one that falls before reset.

// File: rtl/am_slot_overwrite.sv
module am_slot_overwrite #(
  parameter int BLK_W     = 257,
  parameter int FLOWS     = 2,
  parameter int SLOT_BLKS = 8,
  parameter logic [7:0] FILL_BYTE = 8'hC3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [FLOWS*SLOT_BLKS*BLK_W-1:0]   am_bank,
  input  logic                               tx_in_valid,
  output logic                               tx_in_ready,
  input  logic [FLOWS*BLK_W-1:0]             tx_in_data,
  input  logic                               tx_in_sos,
  output logic                               tx_out_valid,
  input  logic                               tx_out_ready,
  output logic [FLOWS*BLK_W-1:0]             tx_out_data,
  output logic                               tx_out_sos,
  output logic                               tx_slot_err,
  input  logic                               rx_lock,
  input  logic                               rx_in_valid,
  output logic                               rx_in_ready,
  input  logic [FLOWS*BLK_W-1:0]             rx_in_data,
  input  logic                               rx_in_sos,
  output logic                               rx_out_valid,
  input  logic                               rx_out_ready,
  output logic [FLOWS*BLK_W-1:0]             rx_out_data,
  output logic                               rx_out_sos,
  output logic                               rx_slot_err
);
  localparam int DW = FLOWS * BLK_W;
  localparam int CW = (SLOT_BLKS > 1) ? $clog2(SLOT_BLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_BLKS - 1);

  function automatic logic [BLK_W-1:0] fill_word(input logic [CW-1:0] k);
    logic [7:0]       pat;
    logic [BLK_W-1:0] w;
    pat = FILL_BYTE ^ 8'(k);
    for (int j = 0; j < BLK_W; j++) w[j] = pat[j % 8];
    return w;
  endfunction

  // transmit side
  logic          tx_fire, tx_busy, tx_mark;
  logic [CW-1:0] tx_cnt, tx_idx;
  logic [DW-1:0] tx_next;

  assign tx_in_ready = !tx_out_valid || tx_out_ready;
  assign tx_fire     = tx_in_valid && tx_in_ready;
  assign tx_busy     = tx_cnt != '0;
  assign tx_mark     = tx_in_sos || tx_busy;
  assign tx_idx      = tx_busy ? tx_cnt : '0;

  for (genvar f = 0; f < FLOWS; f++) begin : g_tx_flow
    assign tx_next[f*BLK_W +: BLK_W] = tx_mark
      ? am_bank[(f*SLOT_BLKS + int'(tx_idx))*BLK_W +: BLK_W]
      : tx_in_data[f*BLK_W +: BLK_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt       <= '0;
      tx_out_valid <= 1'b0;
      tx_out_data  <= '0;
      tx_out_sos   <= 1'b0;
      tx_slot_err  <= 1'b0;
    end else begin
      if (tx_in_ready) tx_out_valid <= tx_in_valid;
      if (tx_fire) begin
        tx_out_data <= tx_next;
        tx_out_sos  <= tx_in_sos;
        if (tx_mark) tx_cnt <= (tx_idx == LAST) ? '0 : tx_idx + 1'b1;
        if (tx_in_sos && tx_busy) tx_slot_err <= 1'b1;
      end
    end
  end

  // receive side
  logic          rx_fire, rx_busy, rx_mark;
  logic [CW-1:0] rx_cnt, rx_idx;
  logic [DW-1:0] rx_next;

  assign rx_in_ready = !rx_out_valid || rx_out_ready;
  assign rx_fire     = rx_in_valid && rx_in_ready;
  assign rx_busy     = rx_cnt != '0;
  assign rx_mark     = rx_in_sos || rx_busy;
  assign rx_idx      = rx_busy ? rx_cnt : '0;

  for (genvar f = 0; f < FLOWS; f++) begin : g_rx_flow
    assign rx_next[f*BLK_W +: BLK_W] = (rx_mark && rx_lock)
      ? fill_word(rx_idx)
      : rx_in_data[f*BLK_W +: BLK_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt       <= '0;
      rx_out_valid <= 1'b0;
      rx_out_data  <= '0;
      rx_out_sos   <= 1'b0;
      rx_slot_err  <= 1'b0;
    end else begin
      if (rx_in_ready) rx_out_valid <= rx_in_valid;
      if (rx_fire) begin
        rx_out_data <= rx_next;
        rx_out_sos  <= rx_in_sos;
        if (rx_mark) rx_cnt <= (rx_idx == LAST) ? '0 : rx_idx + 1'b1;
        if (rx_in_sos && rx_busy) rx_slot_err <= 1'b1;
      end
    end
  end
endmodule

module am_slot_checker #(
  parameter int DW = 514
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_in_valid,
  input logic          tx_in_ready,
  input logic          tx_in_sos,
  input logic          tx_out_valid,
  input logic          tx_out_ready,
  input logic [DW-1:0] tx_out_data,
  input logic          tx_out_sos,
  input logic          tx_slot_err,
  input logic          rx_lock,
  input logic          rx_in_valid,
  input logic          rx_in_ready,
  input logic [DW-1:0] rx_in_data,
  input logic          rx_in_sos,
  input logic          rx_out_valid,
  input logic          rx_out_ready,
  input logic [DW-1:0] rx_out_data,
  input logic          rx_out_sos,
  input logic          rx_slot_err
);
  a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_data) && $stable(tx_out_sos));
  a_r3_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_ready |=> rx_out_valid && $stable(rx_out_data) && $stable(rx_out_sos));
  a_r5_tx_beat_out: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_valid && tx_in_ready |=> tx_out_valid);
  a_r5_tx_no_insert: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_in_valid && tx_in_ready) && tx_out_ready |=> !tx_out_valid);
  a_r7_rx_unlocked_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid && rx_in_ready && !rx_lock |=> rx_out_data == $past(rx_in_data));
  a_r8_tx_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_slot_err) |-> $past(tx_in_valid && tx_in_ready && tx_in_sos));
  a_r8_rx_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_slot_err) |-> $past(rx_in_valid && rx_in_ready && rx_in_sos));
  a_r10_tx_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tx_slot_err |=> tx_slot_err);
  a_r10_rx_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_slot_err |=> rx_slot_err);
endmodule

bind am_slot_overwrite am_slot_checker #(.DW(FLOWS*BLK_W)) u_chk (.*);

// File: tb/tb_am_slot_overwrite.sv
module tb_am_slot_overwrite;
  localparam int BW = 257, NF = 2, NS = 8, DW = NF*BW;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [NF*NS*BW-1:0] am_bank;
  logic tx_in_valid = 0, tx_in_sos = 0, tx_out_ready = 1;
  logic rx_in_valid = 0, rx_in_sos = 0, rx_out_ready = 1, rx_lock = 0;
  logic [DW-1:0] tx_in_data = '0, rx_in_data = '0;
  logic tx_in_ready, tx_out_valid, tx_out_sos, tx_slot_err;
  logic rx_in_ready, rx_out_valid, rx_out_sos, rx_slot_err;
  logic [DW-1:0] tx_out_data, rx_out_data;

  am_slot_overwrite dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [BW-1:0] bank_word(int f, int k);
    logic [BW-1:0] w;
    for (int j = 0; j < BW; j++) w[j] = ((j * 7 + f * 13 + k * 29) % 5) < 2;
    return w;
  endfunction
  function automatic logic [DW-1:0] tx_exp(int k);
    logic [DW-1:0] d;
    for (int f = 0; f < NF; f++) d[f*BW +: BW] = bank_word(f, k);
    return d;
  endfunction
  function automatic logic [DW-1:0] fill_exp(int k);
    logic [DW-1:0] d;
    logic [7:0] b;
    b = 8'hC3 ^ 8'(k);
    for (int j = 0; j < DW; j++) d[j] = b[(j % BW) % 8];
    return d;
  endfunction
  function automatic logic [DW-1:0] mk(int seed);
    logic [DW-1:0] d;
    for (int j = 0; j < DW; j++) d[j] = ((j * 11 + seed * 3) % 7) > 3;
    return d;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic beat(bit rx, logic [DW-1:0] d, bit sos, bit lock,
                      logic [DW-1:0] exp, string req);
    @(negedge clk);
    if (rx) begin rx_in_valid = 1; rx_in_data = d; rx_in_sos = sos; rx_lock = lock; end
    else    begin tx_in_valid = 1; tx_in_data = d; tx_in_sos = sos; end
    @(negedge clk);
    if (rx) begin
      chk({req, " valid"}, DW'(rx_out_valid), DW'(1));
      chk({req, " sos"}, DW'(rx_out_sos), DW'(sos));
      chk(req, rx_out_data, exp);
      rx_in_valid = 0; rx_in_sos = 0;
    end else begin
      chk({req, " valid"}, DW'(tx_out_valid), DW'(1));
      chk({req, " sos"}, DW'(tx_out_sos), DW'(sos));
      chk(req, tx_out_data, exp);
      tx_in_valid = 0; tx_in_sos = 0;
    end
  endtask

  task automatic t_reset;
    chk("R1 tx valid", DW'(tx_out_valid), '0);
    chk("R1 rx valid", DW'(rx_out_valid), '0);
    chk("R1 readies", DW'({tx_in_ready, rx_in_ready}), DW'(2'b11));
    chk("R1 errors", DW'({tx_slot_err, rx_slot_err}), '0);
  endtask

  task automatic t_pass;
    for (int i = 0; i < 3; i++) beat(0, mk(i), 0, 0, mk(i), "R2 tx pass");
    for (int i = 0; i < 3; i++) beat(1, mk(i+9), 0, 1, mk(i+9), "R2 rx pass");
  endtask

  task automatic t_tx_slot;
    for (int k = 0; k < NS; k++) beat(0, mk(20+k), k == 0, 0, tx_exp(k), "R4 tx slot");
    beat(0, mk(40), 0, 0, mk(40), "R5 tx after slot");
    @(negedge clk);
    chk("R5 no extra beat", DW'(tx_out_valid), '0);
  endtask

  task automatic t_rx_slots;
    for (int k = 0; k < NS; k++) beat(1, mk(50+k), k == 0, 0, mk(50+k), "R7 rx unlocked");
    for (int k = 0; k < NS; k++) beat(1, mk(60+k), k == 0, 1, fill_exp(k), "R6 rx locked");
    beat(1, mk(70), 0, 1, mk(70), "R6 rx after slot");
  endtask

  task automatic t_stall;
    @(negedge clk);
    tx_out_ready = 0; tx_in_valid = 1; tx_in_sos = 1; tx_in_data = mk(80);
    @(negedge clk);
    tx_in_sos = 0; tx_in_data = mk(81);
    for (int i = 0; i < 3; i++) begin
      chk("R3 hold data", tx_out_data, tx_exp(0));
      chk("R3 ready low", DW'(tx_in_ready), '0);
      @(negedge clk);
    end
    tx_out_ready = 1;
    @(negedge clk);
    chk("R9 index after stall", tx_out_data, tx_exp(1));
    tx_in_valid = 0;
    for (int k = 2; k < NS; k++) beat(0, mk(80+k), 0, 0, tx_exp(k), "R9 slot resumes");
    beat(0, mk(90), 0, 0, mk(90), "R9 slot ended");
  endtask

  task automatic t_err;
    beat(0, mk(100), 1, 0, tx_exp(0), "R8 tx slot start");
    beat(0, mk(101), 0, 0, tx_exp(1), "R8 tx blk1");
    beat(0, mk(102), 1, 0, tx_exp(2), "R8 tx stray start ignored");
    chk("R8 tx err set", DW'(tx_slot_err), DW'(1));
    for (int k = 3; k < NS; k++) beat(0, mk(100+k), 0, 0, tx_exp(k), "R8 tx continues");
    beat(0, mk(110), 0, 0, mk(110), "R8 tx slot closed");
    chk("R10 tx err sticky", DW'(tx_slot_err), DW'(1));
    chk("R8 rx err clear", DW'(rx_slot_err), '0);
    beat(1, mk(120), 1, 1, fill_exp(0), "R8 rx slot start");
    beat(1, mk(121), 1, 1, fill_exp(1), "R8 rx stray start ignored");
    for (int k = 2; k < NS; k++) beat(1, mk(120+k), 0, 1, fill_exp(k), "R8 rx continues");
    beat(1, mk(130), 0, 1, mk(130), "R8 rx slot closed");
    chk("R10 rx err sticky", DW'(rx_slot_err), DW'(1));
  endtask

  initial begin
    for (int f = 0; f < NF; f++)
      for (int k = 0; k < NS; k++) am_bank[(f*NS+k)*BW +: BW] = bank_word(f, k);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_tx_slot();
    t_rx_slots();
    t_stall();
    t_err();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule